// File: doc/BRIEF.md
# Page-mode nonvolatile RAM model

A clock-sampled behavioural model of a bytewide memory with an asynchronous, SRAM-style pin set. The pins are active-low chip enable, write enable and output enable, an address and a data bus. The data bus is split into an input, an output and an output-enable. Every pin is sampled on the rising edge of `clk`, and all timing is counted in those edges.

The address has two fields. The upper field selects a row and the lower three bits select one of eight bytes in that row. A falling chip enable opens a row and starts an access. While the part stays selected:

- changing only the column gives a short page access;
- changing the row closes the row, precharges it internally and opens the new row, which costs the precharge time plus the full access time.

Writes take the data present when the first of write enable or chip enable rises. The write pulse can either come after the access has started, or write enable can already be low when chip enable falls. The bus stays undriven until an access has completed. A sticky flag records timing violations.

The row field width is a parameter. The default is 8 bits, giving 2K bytes. Setting it to 12 gives the full 32K x 8 organisation.

Top module: `nvram_page_mem`

## Requirements
- R1: After reset, and in any cycle where `dOe` is 0, `dOut` is 0 and `timingErr` is 0 until a violation occurs. Reset clears `timingErr` but not the array.
- R2: `addr[2:0]` is the column and the bits above it are the row. At the first sampled edge with `ceN` low after a high, the address is latched and a read starts if `weN` is high. `dOe` rises T_ACC (default 2) edges after that edge.
- R3: While selected, a change of the column bits alone gives the new byte of the same row T_PAGE (default 1) edges after the edge that samples it.
- R4: While selected, a change of the row bits relatches the address, and data appears T_ACC+T_PC (default 3) edges later.
- R5: `dOe` is 1 only when the part is selected, `oeN` is sampled low, `weN` is sampled high and the access has completed. If `oeN` is low early, the bus stays off until then.
- R6: A write whose `weN` is already low when `ceN` falls stores `dIn` when `ceN` rises.
- R7: A write that starts as a read drives the bus until `weN` is sampled low, then releases it. It stores the `dIn` sampled at the last edge with `weN` low, once `weN` rises.
- R8: When a write ends on the same edge as a column change, the byte goes to the old column and a page access to the new column starts.
- R9: One write pulse stores at most one byte: holding `weN` low across a column change writes only the column open when the pulse ends.
- R10: A write that ends before the access time has elapsed stores nothing and sets `timingErr`.
- R11: `ceN` must stay high for at least T_PC+1 sampled edges between accesses. A shorter gap sets `timingErr`, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ROW_BITS+3 | Byte address: row above, column in bits 2..0 |
| dIn | input | 8 | Write data from the bus |
| dOut | output | 8 | Read data, 0 when not driven |
| dOe | output | 1 | Bus drive enable |
| timingErr | output | 1 | Sticky timing-violation flag |

## Verification
A write termination and a page-mode column change can occur on the same sampled edge. The two then compete for the latched column: the write must use the old one, while the new one must start a page access. The bench provokes this by raising `weN` and moving the column in the same drive step. It then reads both columns back. The old column must hold the new byte and the new column must be unchanged. Holding `weN` low across a column change is also exercised, to show that one pulse stores only one byte.

// File: rtl/nvram_pkg.sv
package nvram_pkg;
  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic latchRow;
    logic latchCol;
    logic commit;
    logic drive;
  } nvStrobe_t;
endpackage

// File: rtl/nvram_datapath.sv
module nvram_datapath
  import nvram_pkg::*;
#(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  nvStrobe_t                    strobe,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic [DATA_W-1:0]            dIn,
  output logic                         rowMatch,
  output logic                         colMatch,
  output logic [DATA_W-1:0]            dOut
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ROW_BITS-1:0] rowQ;
  logic [COL_BITS-1:0] colQ;
  logic [DATA_W-1:0]   dInQ;
  logic [DATA_W-1:0]   cells [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
      dInQ <= '0;
    end else begin
      dInQ <= dIn;
      if (strobe.latchRow) rowQ <= addr[ADDR_W-1:COL_BITS];
      if (strobe.latchCol) colQ <= addr[COL_BITS-1:0];
    end
  end

  // array keeps its content across reset; write uses the address held before this edge
  always_ff @(posedge clk) begin
    if (strobe.commit) cells[{rowQ, colQ}] <= dInQ;
  end

  always_comb begin
    rowMatch = (addr[ADDR_W-1:COL_BITS] == rowQ);
    colMatch = (addr[COL_BITS-1:0] == colQ);
    dOut     = strobe.drive ? cells[{rowQ, colQ}] : '0;
  end
endmodule

// File: rtl/nvram_ctrl.sv
module nvram_ctrl
  import nvram_pkg::*;
#(
  parameter int T_ACC  = 2,
  parameter int T_PAGE = 1,
  parameter int T_PC   = 1,
  parameter int CNT_W  = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      weN,
  input  logic      oeN,
  input  logic      rowMatch,
  input  logic      colMatch,
  output nvStrobe_t strobe,
  output logic      timingErr
);
  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(T_ACC);
  localparam logic [CNT_W-1:0] PAGE_LD = CNT_W'(T_PAGE);
  localparam logic [CNT_W-1:0] ROW_LD  = CNT_W'(T_ACC + T_PC);
  localparam logic [CNT_W-1:0] PC_LD   = CNT_W'(T_PC);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic ceS, weS, oeS, errQ;
  logic [CNT_W-1:0] accCnt, pcCnt;
  logic wasSel, ceFall, ceRise, rowMove, colMove, writeEnd, accDone, violation;

  always_comb begin
    wasSel   = !ceS;
    ceFall   = !ceN && ceS;
    ceRise   = ceN && !ceS;
    rowMove  = !ceN && wasSel && !rowMatch;
    colMove  = !ceN && wasSel && rowMatch && !colMatch;
    accDone  = (accCnt == '0);
    writeEnd = wasSel && !weS && (ceN || weN);
    violation = (ceFall && pcCnt != '0) || (writeEnd && !accDone) || (colMove && !accDone);
    strobe.latchRow = ceFall || rowMove;
    strobe.latchCol = ceFall || rowMove || colMove;
    strobe.commit   = writeEnd && accDone;
    strobe.drive    = wasSel && accDone && !oeS && weS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceS    <= 1'b1;
      weS    <= 1'b1;
      oeS    <= 1'b1;
      accCnt <= '0;
      pcCnt  <= '0;
      errQ   <= 1'b0;
    end else begin
      ceS <= ceN;
      weS <= weN;
      oeS <= oeN;
      if (ceFall)             accCnt <= ACC_LD;
      else if (rowMove)       accCnt <= ROW_LD;
      else if (colMove)       accCnt <= PAGE_LD;
      else if (!accDone)      accCnt <= accCnt - ONE;
      if (ceRise)             pcCnt <= PC_LD;
      else if (pcCnt != '0)   pcCnt <= pcCnt - ONE;
      if (violation)          errQ <= 1'b1;
    end
  end

  assign timingErr = errQ;
endmodule

// File: rtl/nvram_page_mem.sv
module nvram_page_mem
  import nvram_pkg::*;
#(
  parameter int ROW_BITS = 8,
  parameter int T_ACC    = 2,
  parameter int T_PAGE   = 1,
  parameter int T_PC     = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  weN,
  input  logic                  oeN,
  input  logic [ROW_BITS+2:0]   addr,
  input  logic [7:0]            dIn,
  output logic [7:0]            dOut,
  output logic                  dOe,
  output logic                  timingErr
);
  localparam int COL_BITS = 3;
  localparam int CNT_W    = $clog2(T_ACC + T_PC + T_PAGE + 1) + 1;

  nvStrobe_t strobe;
  logic rowMatch, colMatch;

  nvram_ctrl #(
    .T_ACC(T_ACC), .T_PAGE(T_PAGE), .T_PC(T_PC), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .rowMatch(rowMatch), .colMatch(colMatch),
    .strobe(strobe), .timingErr(timingErr)
  );

  nvram_datapath #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(8)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .dIn(dIn),
    .rowMatch(rowMatch), .colMatch(colMatch), .dOut(dOut)
  );

  assign dOe = strobe.drive;
endmodule

// File: rtl/nvram_checker.sv
module nvram_checker #(
  parameter int ROW_BITS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                ceN,
  input logic                weN,
  input logic [ROW_BITS-1:0] rowAddr,
  input logic [7:0]          dOut,
  input logic                dOe,
  input logic                timingErr
);
  p_zero_when_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !dOe |-> (dOut == 8'h00));

  p_quiet_after_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ceN) |=> !dOe);

  p_quiet_after_row_move_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !$past(ceN) && rowAddr != $past(rowAddr)) |=> !dOe);

  p_off_when_deselected_r5: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> !dOe);

  p_off_during_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    !weN |=> !dOe);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    timingErr |=> timingErr);
endmodule

bind nvram_page_mem nvram_checker #(.ROW_BITS(ROW_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN),
  .rowAddr(addr[ROW_BITS+2:3]), .dOut(dOut), .dOe(dOe), .timingErr(timingErr)
);

// File: tb/nvram_page_mem_tb_top.sv
`timescale 1ns/1ps
module nvram_page_mem_tb_top;
  localparam int ROW_BITS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [ROW_BITS+2:0] addr = '0;
  logic [7:0] dIn = '0;
  logic [7:0] dOut;
  logic dOe, timingErr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nvram_page_mem #(.ROW_BITS(ROW_BITS)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOe(dOe), .timingErr(timingErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic deselect();
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
    step(2);
  endtask

  task automatic tReset();
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    step(3);
    rstN = 1'b1;
    step(2);
    check("R1 dOe after reset", dOe, 0);
    check("R1 dOut after reset", dOut, 0);
    check("R1 timingErr after reset", timingErr, 0);
  endtask

  // write enable already low when chip enable falls
  task automatic ceWrite(input logic [10:0] a, input logic [7:0] d);
    addr = a; dIn = d; weN = 1'b0; oeN = 1'b0; ceN = 1'b0;
    step(3);
    check("R5 no drive while weN low", dOe, 0);
    ceN = 1'b1;
    step(1);
    weN = 1'b1; oeN = 1'b1;
    step(1);
  endtask

  // opens a read and checks latency; leaves the part selected
  task automatic openRead(input logic [10:0] a, input logic [7:0] exp, input string req);
    addr = a; weN = 1'b1; oeN = 1'b0; ceN = 1'b0;
    step(1); check({req, " R5 early oe stays off"}, dOe, 0);
    step(1); check({req, " R2 still in access"}, dOe, 0);
    step(1); check({req, " R2 driven after T_ACC"}, dOe, 1);
    check({req, " data"}, dOut, exp);
  endtask

  task automatic pageRead(input logic [2:0] col, input logic [7:0] exp, input string req);
    addr[2:0] = col;
    step(1); check({req, " R3 page latency"}, dOe, 0);
    step(1); check({req, " R3 page drive"}, dOe, 1);
    check({req, " R3 page data"}, dOut, exp);
  endtask

  task automatic rowChange(input logic [10:0] a, input logic [7:0] exp);
    addr = a;
    step(1); check("R4 off after row change", dOe, 0);
    step(1); check("R4 off during precharge", dOe, 0);
    step(1); check("R4 off before access end", dOe, 0);
    step(1); check("R4 drive after T_ACC+T_PC", dOe, 1);
    check("R4 new row data", dOut, exp);
  endtask

  task automatic readBack(input logic [10:0] a, input logic [7:0] exp, input string req);
    openRead(a, exp, req);
    deselect();
  endtask

  // write cycle starting as a read
  task automatic weWrite(input logic [10:0] a, input logic [7:0] d);
    addr = a; dIn = d; weN = 1'b1; oeN = 1'b0; ceN = 1'b0;
    step(3); check("R7 starts as read", dOe, 1);
    weN = 1'b0;
    step(1); check("R7 bus released when weN low", dOe, 0);
    check("R1 dOut zero when released", dOut, 0);
    weN = 1'b1;
    step(1);
    deselect();
  endtask

  // page write in an open row
  task automatic writeCol(input logic [2:0] col, input logic [7:0] d);
    addr[2:0] = col; dIn = d;
    step(1); weN = 1'b0;
    step(1); weN = 1'b1;
    step(1);
  endtask

  task automatic tPageWrite();
    addr = 11'h080; weN = 1'b1; oeN = 1'b1; ceN = 1'b0;
    step(3);
    for (int c = 0; c < 8; c++) writeCol(3'(c), 8'h10 + 8'(c));
    deselect();
    check("R3 no error in page writes", timingErr, 0);
  endtask

  task automatic tPageRead();
    openRead(11'h080, 8'h10, "R2 open row");
    pageRead(3'd1, 8'h11, "R3 col1");
    pageRead(3'd7, 8'h17, "R3 col7");
    pageRead(3'd4, 8'h14, "R3 col4");
    rowChange(11'h123, 8'h5A);
    deselect();
  endtask

  task automatic tSameEdge();
    addr = 11'h085; dIn = 8'hA5; weN = 1'b1; oeN = 1'b1; ceN = 1'b0;
    step(3);
    weN = 1'b0;
    step(1);
    weN = 1'b1; addr[2:0] = 3'd6;
    step(2);
    deselect();
    check("R8 no error", timingErr, 0);
    readBack(11'h085, 8'hA5, "R8 old column written");
    readBack(11'h086, 8'h16, "R8 new column untouched");
  endtask

  task automatic tHeldWe();
    addr = 11'h081; weN = 1'b1; oeN = 1'b1; ceN = 1'b0;
    step(3);
    dIn = 8'hEE; weN = 1'b0;
    step(2);
    addr[2:0] = 3'd2; dIn = 8'h77;
    step(2);
    weN = 1'b1;
    step(1);
    deselect();
    readBack(11'h081, 8'h11, "R9 first column untouched");
    readBack(11'h082, 8'h77, "R9 final column written");
  endtask

  task automatic tEarlyWriteEnd();
    check("R10 no error before", timingErr, 0);
    addr = 11'h123; dIn = 8'h99; weN = 1'b0; ceN = 1'b0;
    step(1);
    ceN = 1'b1;
    step(1);
    check("R10 error on short write", timingErr, 1);
    weN = 1'b1;
    step(2);
    readBack(11'h123, 8'h5A, "R10 short write not stored");
  endtask

  task automatic tPrecharge();
    openRead(11'h2F0, 8'hC3, "R11 baseline");
    check("R11 no error with long precharge", timingErr, 0);
    ceN = 1'b1;
    step(1);
    ceN = 1'b0;
    step(1);
    check("R11 error on short precharge", timingErr, 1);
    deselect();
    step(5);
    check("R11 error sticky", timingErr, 1);
  endtask

  initial begin
    tReset();
    ceWrite(11'h123, 8'h5A);
    readBack(11'h123, 8'h5A, "R6 ce-controlled write");
    weWrite(11'h2F0, 8'hC3);
    readBack(11'h2F0, 8'hC3, "R7 we-controlled write");
    tPageWrite();
    tPageRead();
    tSameEdge();
    tHeldWe();
    tEarlyWriteEnd();
    tReset();
    readBack(11'h084, 8'h14, "R1 array kept over reset");
    tPrecharge();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule